// File: doc/BRIEF.md
# Stereo Sample Attenuator with Soft Mute

This block scales a left and a right stream of 24-bit two's-complement audio samples by a separate 10-bit attenuation code for each channel. It also fades both channels to silence on a mute request. It sits after the serial audio input and before any filtering or modulation.

Attenuation codes are captured on a load pulse, but they are not applied at once. A captured code reaches the multiplier only at the next frame-boundary pulse, which is derived from the word-select edge, so the gain never changes in the middle of a stereo frame.

Mute can come from a pin or from a control bit; either one mutes both channels. Muting does not cut the gain. An internal gain level steps down by a fixed amount once per frame until it reaches zero. On release it climbs back by the same step to the programmed level, so the output has no click.

Top module: `vol_fader`

## Requirements
- R1: After reset both output valids are low and both output samples are zero; both channels start at code 0x3FF, so a sample passes through unchanged.
- R2: An output valid rises exactly two clock cycles after the matching input valid, and each channel's strobe is independent of the other's.
- R3: The output sample equals floor(sample × G / 1024), where G is the channel's current gain level; an unmuted, settled channel has G = code + 1. This holds for negative samples as well, so code 0x000 maps -1000 to -1.
- R4: A code captured on `code_load` has no effect on the output until the next `frame_tick`, and it applies from that tick on.
- R5: When `code_load` and `frame_tick` occur in the same cycle, that tick applies the previously captured code, and the newly captured code waits for the following tick.
- R6: While `mute_pin` is high, each `frame_tick` lowers both gain levels by STEP (64 by default), stopping at zero; from full scale, 16 ticks give a zero output.
- R7: `mute_reg` high has the same effect as `mute_pin`; the two are ORed.
- R8: After mute is released, each `frame_tick` raises the gain level by STEP until it reaches code + 1, where it clamps and then tracks the code.
- R9: The mute inputs are sampled only on `frame_tick`; the gain level never changes in a cycle without a tick.
- R10: A code loaded while muted does not interrupt the fade; after release, the ramp targets the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| l_data | input | 24 | Left input sample, two's complement |
| l_valid | input | 1 | Left input strobe |
| r_data | input | 24 | Right input sample, two's complement |
| r_valid | input | 1 | Right input strobe |
| l_code | input | 10 | Left attenuation code, 0x3FF = 0 dB |
| r_code | input | 10 | Right attenuation code |
| code_load | input | 1 | Capture pulse for both codes |
| mute_reg | input | 1 | Mute request from the control register |
| mute_pin | input | 1 | Mute request from the pin |
| frame_tick | input | 1 | One-cycle frame-boundary pulse |
| o_l_data | output | 24 | Attenuated left sample |
| o_l_valid | output | 1 | Left output strobe |
| o_r_data | output | 24 | Attenuated right sample |
| o_r_valid | output | 1 | Right output strobe |

## Verification
The gain level is internal, and it moves only on frame ticks, so ramp points are hard to observe from the ports. The bench reads the level directly by sending a probe sample of 1024: with that input the output equals the level exactly. It probes between single ticks through a full 16-step fade, through a partial unmute in which one channel clamps early at a low code, and through a code reload made during mute. It also places a load in the same cycle as a tick and then probes again to show which code that tick applied.

// File: rtl/att_pkg.sv
package att_pkg;
  // Gain tracker behaviour: follow the code directly, or move in steps.
  typedef enum logic [0:0] {
    GS_TRACK = 1'b0,
    GS_RAMP  = 1'b1
  } gain_state_e;
endpackage

// File: rtl/att_code_hold.sv
module att_code_hold #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] code_in,
  output logic [CW-1:0] pending
);
  localparam logic [CW-1:0] FULL = '1;

  always_ff @(posedge clk) begin
    if (rst) pending <= FULL;
    else if (load) pending <= code_in;
  end
endmodule

// File: rtl/att_gain_ramp.sv
module att_gain_ramp
  import att_pkg::*;
#(
  parameter int CW   = 10,
  parameter int STEP = 64,
  localparam int LW  = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          mute,
  input  logic [CW-1:0] code,
  output logic [LW-1:0] level
);
  localparam logic [LW:0]   STEP_W = (LW+1)'(STEP);
  localparam logic [LW-1:0] STEP_L = LW'(STEP);
  localparam logic [LW-1:0] FULL_L = LW'(1) << CW;

  gain_state_e state;
  logic [LW-1:0] target;
  logic [LW:0]   raised;

  always_comb begin
    target = LW'(code) + LW'(1);
    raised = {1'b0, level} + STEP_W;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= FULL_L;
      state <= GS_TRACK;
    end else if (tick) begin
      if (mute) begin
        state <= GS_RAMP;
        level <= (level > STEP_L) ? level - STEP_L : '0;
      end else if (state == GS_RAMP) begin
        if (raised >= {1'b0, target}) begin
          level <= target;
          state <= GS_TRACK;
        end else begin
          level <= raised[LW-1:0];
        end
      end else begin
        level <= target;
      end
    end
  end
endmodule

// File: rtl/att_scale_pipe.sv
module att_scale_pipe #(
  parameter int DW  = 24,
  parameter int CW  = 10,
  localparam int LW = CW + 1,
  localparam int PW = DW + LW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          din_valid,
  input  logic [LW-1:0] level,
  output logic [DW-1:0] dout,
  output logic          dout_valid
);
  logic signed [PW-1:0] prod_q;
  logic                 v_q;
  logic signed [PW-1:0] shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      v_q    <= 1'b0;
    end else begin
      v_q <= din_valid;
      if (din_valid) prod_q <= $signed(din) * $signed({1'b0, level});
    end
  end

  always_comb shifted = prod_q >>> CW;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= v_q;
      if (v_q) dout <= DW'(shifted);
    end
  end
endmodule

// File: rtl/vol_fader.sv
module vol_fader #(
  parameter int DW   = 24,
  parameter int CW   = 10,
  parameter int STEP = 64,
  localparam int LW  = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] l_data,
  input  logic          l_valid,
  input  logic [DW-1:0] r_data,
  input  logic          r_valid,
  input  logic [CW-1:0] l_code,
  input  logic [CW-1:0] r_code,
  input  logic          code_load,
  input  logic          mute_reg,
  input  logic          mute_pin,
  input  logic          frame_tick,
  output logic [DW-1:0] o_l_data,
  output logic          o_l_valid,
  output logic [DW-1:0] o_r_data,
  output logic          o_r_valid
);
  localparam int NCH = 2;

  logic [DW-1:0] din   [NCH];
  logic          dvin  [NCH];
  logic [CW-1:0] cin   [NCH];
  logic [CW-1:0] pend  [NCH];
  logic [LW-1:0] lvl   [NCH];
  logic [DW-1:0] dout  [NCH];
  logic          dvout [NCH];
  logic          mute_any;
  logic [LW-1:0] lvl_l, lvl_r;

  always_comb begin
    mute_any = mute_reg | mute_pin;
    din[0] = l_data;  dvin[0] = l_valid; cin[0] = l_code;
    din[1] = r_data;  dvin[1] = r_valid; cin[1] = r_code;
    lvl_l = lvl[0];
    lvl_r = lvl[1];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    att_code_hold #(.CW(CW)) u_hold (
      .clk(clk), .rst(rst), .load(code_load),
      .code_in(cin[ch]), .pending(pend[ch])
    );
    att_gain_ramp #(.CW(CW), .STEP(STEP)) u_ramp (
      .clk(clk), .rst(rst), .tick(frame_tick), .mute(mute_any),
      .code(pend[ch]), .level(lvl[ch])
    );
    att_scale_pipe #(.DW(DW), .CW(CW)) u_pipe (
      .clk(clk), .rst(rst), .din(din[ch]), .din_valid(dvin[ch]),
      .level(lvl[ch]), .dout(dout[ch]), .dout_valid(dvout[ch])
    );
  end

  always_comb begin
    o_l_data  = dout[0];
    o_l_valid = dvout[0];
    o_r_data  = dout[1];
    o_r_valid = dvout[1];
  end
endmodule

// File: rtl/vol_fader_chk.sv
module vol_fader_chk #(
  parameter int CW   = 10,
  parameter int STEP = 64,
  localparam int LW  = CW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          l_valid,
  input logic          r_valid,
  input logic          o_l_valid,
  input logic          o_r_valid,
  input logic          mute_reg,
  input logic          mute_pin,
  input logic          frame_tick,
  input logic [LW-1:0] lvl_l,
  input logic [LW-1:0] lvl_r
);
  localparam logic [LW-1:0] FULL_L = LW'(1) << CW;
  localparam logic [LW-1:0] STEP_L = LW'(STEP);

  p_lat_l_r2: assert property (@(posedge clk) disable iff (rst)
    l_valid |-> ##2 o_l_valid);
  p_lat_r_r2: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> ##2 o_r_valid);
  p_nolat_l_r2: assert property (@(posedge clk) disable iff (rst)
    !l_valid |-> ##2 !o_l_valid);
  p_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (lvl_l <= FULL_L) && (lvl_r <= FULL_L));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(lvl_l) && $stable(lvl_r));
  p_fade_r6: assert property (@(posedge clk) disable iff (rst)
    frame_tick && (mute_pin || mute_reg) && (lvl_l >= STEP_L)
    |=> lvl_l == $past(lvl_l) - STEP_L);
  p_floor_r7: assert property (@(posedge clk) disable iff (rst)
    frame_tick && (mute_pin || mute_reg) && (lvl_r <= STEP_L)
    |=> lvl_r == '0);
endmodule

bind vol_fader vol_fader_chk #(.CW(CW), .STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .l_valid(l_valid), .r_valid(r_valid),
  .o_l_valid(o_l_valid), .o_r_valid(o_r_valid), .mute_reg(mute_reg),
  .mute_pin(mute_pin), .frame_tick(frame_tick), .lvl_l(lvl_l), .lvl_r(lvl_r)
);

// File: tb/vol_fader_bench.sv
module vol_fader_bench;
  localparam int DW = 24;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] l_data = '0, r_data = '0;
  logic l_valid = 1'b0, r_valid = 1'b0;
  logic [CW-1:0] l_code = '0, r_code = '0;
  logic code_load = 1'b0, mute_reg = 1'b0, mute_pin = 1'b0, frame_tick = 1'b0;
  logic [DW-1:0] o_l_data, o_r_data;
  logic o_l_valid, o_r_valid;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  vol_fader u_vol_fader (
    .clk(clk), .rst(rst), .l_data(l_data), .l_valid(l_valid),
    .r_data(r_data), .r_valid(r_valid), .l_code(l_code), .r_code(r_code),
    .code_load(code_load), .mute_reg(mute_reg), .mute_pin(mute_pin),
    .frame_tick(frame_tick), .o_l_data(o_l_data), .o_l_valid(o_l_valid),
    .o_r_data(o_r_data), .o_r_valid(o_r_valid)
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint scale(longint s, longint g);
    return (s * g) >>> 10;
  endfunction

  // Send one sample per channel; checks R2 timing, returns outputs.
  task automatic send(input logic signed [DW-1:0] ls, input logic signed [DW-1:0] rs,
                      output longint lo, output longint ro);
    @(negedge clk);
    l_data = ls; r_data = rs; l_valid = 1'b1; r_valid = 1'b1;
    @(negedge clk);
    l_valid = 1'b0; r_valid = 1'b0;
    check("R2", o_l_valid, 0);
    @(negedge clk);
    check("R2", o_l_valid, 1);
    check("R2", o_r_valid, 1);
    lo = longint'($signed(o_l_data));
    ro = longint'($signed(o_r_data));
  endtask

  task automatic probe(string req, longint el, longint er);
    longint lo, ro;
    send(24'sd1024, 24'sd1024, lo, ro);
    check(req, lo, el);
    check(req, ro, er);
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic load(logic [CW-1:0] lc, logic [CW-1:0] rc, bit with_tick);
    @(negedge clk);
    l_code = lc; r_code = rc; code_load = 1'b1; frame_tick = with_tick;
    @(negedge clk);
    code_load = 1'b0; frame_tick = 1'b0;
  endtask

  task automatic t_reset();
    longint lo, ro;
    check("R1", o_l_valid, 0);
    check("R1", o_r_valid, 0);
    check("R1", o_l_data, 0);
    check("R1", o_r_data, 0);
    send(-24'sd123457, 24'sd654321, lo, ro);
    check("R1", lo, -123457);
    check("R1", ro, 654321);
  endtask

  task automatic t_gain();
    longint lo, ro;
    load(10'h1FF, 10'h000, 0);
    probe("R4", 1024, 1024);
    tick();
    probe("R4", 512, 1);
    send(-24'sd1000, -24'sd1000, lo, ro);
    check("R3", lo, -500);
    check("R3", ro, -1);
    send(24'sh7FFFFF, 24'sh800000, lo, ro);
    check("R3", lo, scale(8388607, 512));
    check("R3", ro, scale(-8388608, 1));
  endtask

  task automatic t_same_cycle();
    load(10'h0FF, 10'h0FF, 1);
    probe("R5", 512, 1);
    tick();
    probe("R5", 256, 256);
  endtask

  task automatic t_one_side();
    @(negedge clk); l_valid = 1'b1; l_data = 24'sd5;
    @(negedge clk); l_valid = 1'b0;
    @(negedge clk);
    check("R2", o_l_valid, 1);
    check("R2", o_r_valid, 0);
  endtask

  task automatic t_mute_pin();
    longint lo, ro;
    load(10'h3FF, 10'h3FF, 0);
    tick();
    probe("R6", 1024, 1024);
    mute_pin = 1'b1;
    repeat (6) @(negedge clk);
    probe("R9", 1024, 1024);
    tick();
    probe("R6", 960, 960);
    for (int i = 0; i < 15; i++) tick();
    probe("R6", 0, 0);
    tick();
    send(24'sh123456, -24'sd77, lo, ro);
    check("R6", lo, 0);
    check("R6", ro, 0);
  endtask

  task automatic t_unmute();
    mute_pin = 1'b0;
    load(10'h3FF, 10'h09F, 0);
    probe("R9", 0, 0);
    tick();
    probe("R8", 64, 64);
    tick();
    probe("R8", 128, 128);
    tick();
    probe("R8", 192, 160);
    for (int i = 0; i < 13; i++) tick();
    probe("R8", 1024, 160);
    tick();
    probe("R8", 1024, 160);
  endtask

  task automatic t_mute_bit();
    mute_reg = 1'b1;
    tick();
    probe("R7", 960, 96);
    tick();
    probe("R7", 896, 32);
    tick();
    probe("R7", 832, 0);
  endtask

  task automatic t_load_muted();
    load(10'h07F, 10'h09F, 0);
    tick();
    probe("R10", 768, 0);
    mute_reg = 1'b0;
    tick();
    probe("R10", 128, 64);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gain();
    t_same_cycle();
    t_one_side();
    t_mute_pin();
    t_unmute();
    t_mute_bit();
    t_load_muted();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule